// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

This block is a per-core countdown timer for an interrupt controller. Software sets a clock divider, a control entry (interrupt vector, mask and mode) and an initial count through a small register port. Writing the initial count loads the counter and starts the countdown. The counter moves down by one for every N pulses of a timebase enable input, where N comes from the divider setting.

When the counter reaches zero, the block raises a one-cycle interrupt request and presents the programmed vector beside it. What happens next depends on the mode. In one-shot mode the counter stays at zero until software writes a new initial count. In periodic mode the counter reloads from the initial count and runs again.

Register reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `cd_timer`

## Requirements
- R1: After reset, the control entry (0x320) reads 0x0001_0000: mask bit 16 is set, mode bit 17 is 0 (one-shot) and vector bits 7:0 are 0. The divide register (0x3E0), initial count (0x380) and current count (0x390) all read 0, and irq_req is low.
- R2: The divide code is {bit 3, bit 1, bit 0} of the divide register. Codes 000 to 110 select N = 2, 4, 8, 16, 32, 64 and 128 in that order, and code 111 selects N = 1. A running counter decrements once for every N timebase enables.
- R3: The divide register reads back bits 3, 1 and 0 as written. Bit 2 and every other bit read as zero.
- R4: A write to the initial count stores the value, copies it into the current count, starts the countdown and restarts the prescaler phase. The first decrement therefore comes on the N-th enable after the write.
- R5: In one-shot mode, the step that takes the count from 1 to 0 sets irq_req for exactly the one cycle in which the current count first reads 0. The count then stays at 0.
- R6: In periodic mode (entry bit 17 set), the expiring step pulses irq_req and reloads the current count from the initial count. Requests therefore repeat every init×N enables.
- R7: A write to the divide register restarts the prescaler phase. The next decrement then needs a full N enables.
- R8: Writing an initial count of zero leaves the timer stopped at zero, and no request is raised.
- R9: While entry bit 16 (mask) is set, irq_req stays low. The countdown still runs and expires as normal.
- R10: Writes to the current count address are ignored.
- R11: If an initial count write lands on the same edge as the expiring step, the write wins. The counter loads the new value and no request is raised for the old count.
- R12: irq_vec always shows entry bits 7:0.
- R13: With the timebase enable held low, the current count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase enable pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_req | output | 1 | One-cycle timer interrupt request |
| irq_vec | output | 8 | Vector of the timer interrupt |

## Verification
Two things can happen on the same edge: a software write of the initial count and the final decrement that would expire the count. The bench provokes this with divide-by-1 and a count of 3. It waits until the current count reads 1, then issues the new initial count write on the next edge, which is exactly when the expiring step would occur. The result is judged at the ports: irq_req must stay low, the current count must read the newly written value, and the next request must come after a full new countdown. A similar collision, a divide write landing mid-phase, is judged by the number of cycles until the next request.

// File: rtl/cd_timer_pkg.sv
package cd_timer_pkg;
    localparam int ADDR_W = 12;
    localparam int PS_W   = 8;
    localparam int VEC_W  = 8;
    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;

    localparam logic [ADDR_W-1:0] A_ENTRY = 12'h320;
    localparam logic [ADDR_W-1:0] A_INIT  = 12'h380;
    localparam logic [ADDR_W-1:0] A_CUR   = 12'h390;
    localparam logic [ADDR_W-1:0] A_DIV   = 12'h3E0;

    // Divide ratio for the 3-bit code {b3,b1,b0}; all-ones means divide by 1.
    function automatic logic [PS_W-1:0] div_ratio(input logic [2:0] code);
        logic [PS_W-1:0] two;
        two = {{(PS_W-2){1'b0}}, 2'b10};
        if (code == 3'b111) return {{(PS_W-1){1'b0}}, 1'b1};
        return two << code;
    endfunction
endpackage

// File: rtl/cd_timer_prescale.sv
module cd_timer_prescale #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            restart,
    input  logic [PS_W-1:0] ratio,
    output logic            step
);
    localparam logic [PS_W-1:0] PS_ONE = {{(PS_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PS_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = tick_en && (st_q.phase == ratio - PS_ONE);
        if (restart) begin
            st_d.phase = '0;
        end else if (tick_en) begin
            st_d.phase = step ? '0 : st_q.phase + PS_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < ratio);
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.phase == '0);
endmodule

// File: rtl/cd_timer_core.sv
module cd_timer_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             active;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (load) begin
            st_d.cur    = load_val;
            st_d.active = (load_val != '0);
        end else if (step && st_q.active) begin
            if (st_q.cur == C_ONE) begin
                fire = 1'b1;
                if (periodic) begin
                    st_d.cur = reload_val;
                end else begin
                    st_d.cur    = '0;
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.cur = st_q.cur - C_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cur;

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !load) |=> $stable(count));
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && step && !load && count > C_ONE) |=> count == $past(count) - C_ONE);
    assert_no_step_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));
endmodule

// File: rtl/cd_timer.sv
module cd_timer
    import cd_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             mask;
        logic             periodic;
        logic [2:0]       div;
        logic [CNT_W-1:0] init;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             wr_entry, wr_init, wr_div;
    logic             step, fire;
    logic [CNT_W-1:0] count;
    logic [PS_W-1:0]  ratio;

    assign wr_entry = reg_wr && (reg_addr == A_ENTRY);
    assign wr_init  = reg_wr && (reg_addr == A_INIT);
    assign wr_div   = reg_wr && (reg_addr == A_DIV);
    assign ratio    = div_ratio(st_q.div);

    always_comb begin
        st_d     = st_q;
        st_d.irq = fire && !st_q.mask;
        if (wr_entry) begin
            st_d.vec      = reg_wdata[VEC_W-1:0];
            st_d.mask     = reg_wdata[MASK_BIT];
            st_d.periodic = reg_wdata[MODE_BIT];
        end
        if (wr_div)  st_d.div  = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
        if (wr_init) st_d.init = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENTRY: begin
                reg_rdata[VEC_W-1:0] = st_q.vec;
                reg_rdata[MASK_BIT]  = st_q.mask;
                reg_rdata[MODE_BIT]  = st_q.periodic;
            end
            A_DIV: begin
                reg_rdata[3] = st_q.div[2];
                reg_rdata[1] = st_q.div[1];
                reg_rdata[0] = st_q.div[0];
            end
            A_INIT:  reg_rdata = st_q.init;
            A_CUR:   reg_rdata = count;
            default: reg_rdata = '0;
        endcase
    end

    cd_timer_prescale #(.PS_W(PS_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (wr_init || wr_div),
        .ratio   (ratio),
        .step    (step)
    );

    cd_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_init),
        .load_val   (reg_wdata),
        .reload_val (st_q.init),
        .periodic   (st_q.periodic),
        .step       (step),
        .count      (count),
        .fire       (fire)
    );

    assign irq_req = st_q.irq;
    assign irq_vec = st_q.vec;

    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.mask) |=> !irq_req);
    assert_request_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !st_q.mask) |=> irq_req);
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !st_q.periodic) |=> !irq_req);
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_init |-> !fire);
endmodule

// File: tb/cd_timer_tb.sv
`timescale 1ns/1ps
module cd_timer_tb;
    localparam logic [11:0] A_ENTRY = 12'h320;
    localparam logic [11:0] A_INIT  = 12'h380;
    localparam logic [11:0] A_CUR   = 12'h390;
    localparam logic [11:0] A_DIV   = 12'h3E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = 12'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    cd_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write happens on the next posedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_CUR;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_addr = A_CUR;
    endtask

    task automatic wait_irq(input int max, output int n);
        n = 0;
        while (!irq_req && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (irq_req) seen++;
        end
    endtask

    function automatic int ratio_of(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    function automatic logic [31:0] entry(input bit periodic, input bit mask, input logic [7:0] vec);
        return (32'(periodic) << 17) | (32'(mask) << 16) | 32'(vec);
    endfunction

    initial begin
        logic [31:0] v;
        int n, seen, nn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_ENTRY, v); check("R1 entry", v, 32'h0001_0000);
        rd(A_DIV, v);   check("R1 divide", v, 0);
        rd(A_INIT, v);  check("R1 init", v, 0);
        rd(A_CUR, v);   check("R1 current", v, 0);
        check("R1 irq", 32'(irq_req), 0);

        tick_en = 1'b1;
        wr(A_ENTRY, entry(1'b0, 1'b0, 8'h3C));

        // R2 R3 R4 R5 sweep all divide codes, one-shot, count 3
        for (int code = 0; code < 8; code++) begin
            logic [31:0] dv;
            dv = {28'h0, code[2], 1'b1, code[1], code[0]};
            wr(A_DIV, dv);
            rd(A_DIV, v);
            check("R3 divide readback", v, {28'h0, code[2], 1'b0, code[1], code[0]});
            wr(A_INIT, 32'd3);
            rd(A_CUR, v); check("R4 loaded", v, 3);
            wait_irq(2000, n);
            check("R2 cycles to expiry", 32'(n), 32'(3 * ratio_of(code)));
            rd(A_CUR, v); check("R5 zero at request", v, 0);
            check("R12 vector", 32'(irq_vec), 32'h3C);
            idle(2 * ratio_of(code) + 2, seen);
            check("R5 single pulse then silent", 32'(seen), 0);
            rd(A_CUR, v); check("R5 holds zero", v, 0);
        end

        // R6 periodic, divide by 1, count 4
        wr(A_DIV, 32'h0000_000B);
        wr(A_ENTRY, entry(1'b1, 1'b0, 8'h51));
        wr(A_INIT, 32'd4);
        wait_irq(100, n);
        check("R6 first interval", 32'(n), 4);
        rd(A_CUR, v); check("R6 reload", v, 4);
        @(negedge clk);
        check("R6 pulse width", 32'(irq_req), 0);
        wait_irq(100, nn);
        check("R6 second interval", 32'(nn + 1), 4);
        check("R12 vector periodic", 32'(irq_vec), 32'h51);

        // R9 mask: countdown still expires, no request
        wr(A_ENTRY, entry(1'b0, 1'b1, 8'h51));
        wr(A_INIT, 32'd5);
        idle(10, seen);
        check("R9 masked no request", 32'(seen), 0);
        rd(A_CUR, v); check("R9 countdown ran", v, 0);
        wr(A_ENTRY, entry(1'b0, 1'b0, 8'h51));

        // R8 zero initial count
        wr(A_INIT, 32'd0);
        idle(20, seen);
        check("R8 no request", 32'(seen), 0);
        rd(A_CUR, v); check("R8 stays zero", v, 0);

        // R10 R13 current count write ignored, frozen without enable
        tick_en = 1'b0;
        wr(A_INIT, 32'd9);
        wr(A_CUR, 32'd123);
        idle(5, seen);
        rd(A_CUR, v); check("R10 R13 current unchanged", v, 9);
        tick_en = 1'b1;

        // R11 init write on the expiring edge
        wr(A_INIT, 32'd3);
        @(negedge clk);
        @(negedge clk);
        rd(A_CUR, v); check("R11 pre-collision count", v, 1);
        wr(A_INIT, 32'd7);
        check("R11 no request", 32'(irq_req), 0);
        rd(A_CUR, v); check("R11 new count", v, 7);
        wait_irq(100, n);
        check("R11 full new countdown", 32'(n), 7);

        // R7 divide write restarts phase (divide by 4)
        wr(A_DIV, 32'h0000_0001);
        wr(A_INIT, 32'd2);
        @(negedge clk);
        @(negedge clk);
        wr(A_DIV, 32'h0000_0001);
        wait_irq(100, n);
        check("R7 phase restart", 32'(n), 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule